// File: doc/BRIEF.md
# Tile slice loader

This block carries out one predicated load of 64-bit words into a single row or column of a square tile held in a bank of tile registers. A decoded request supplies a tile number, a row/column select, a 32-bit slice index with a one-bit immediate increment, a byte-granular predicate, a 64-bit base address and a 64-bit element offset. The block walks the elements of the vector in ascending order. It issues one memory read for each element the predicate enables. It fills disabled elements with zero without touching memory.

Once every element has been collected, the whole vector is written into the selected slice of the tile in a single cycle. A combinational readback port returns any row or column of any tile, so the tile contents can be observed. The vector length is a parameter: the default of 256 bits gives four elements per vector and eight 4x4 tiles of 64-bit words.

The memory request port uses valid/ready. The block raises `mem_req_valid` with an address and holds both unchanged until `mem_req_ready` is seen high at a clock edge. Only one read is outstanding at a time, and no new request appears until its response has returned. The response channel has no back-pressure: for each accepted request, the memory must pulse `mem_rsp_valid` exactly once with the data, at least one cycle after the acceptance. The block accepts that response in whatever cycle it arrives.

Top module: `tile_slice_loader`

## Requirements
- R1: The target slice is (slice index + immediate increment) modulo the number of elements per vector. The sum is taken without 32-bit wrap, so index 0xFFFFFFFF plus 1 selects slice 0.
- R2: The read for element e uses address base + (element offset + e) * 8, computed modulo 2^64. Reads are issued in ascending element order.
- R3: Element e is enabled only by predicate bit 8*e, and the other predicate bits have no effect. A disabled element issues no read and stores all zeros.
- R4: For an enabled element, the data of the response to its read is stored as that element. Element e occupies bits [64e+63:64e] of a vector.
- R5: With the select at 0, element e is written to row `slice`, column e of the tile. With the select at 1, it is written to row e, column `slice`. Readback with `rd_vert`=0 returns row `rd_slice` of tile `rd_tile`, and with `rd_vert`=1 it returns column `rd_slice`; element e of either sits at bits [64e+63:64e].
- R6: The tile bank changes only in the single cycle after the last element has been collected. No partly loaded slice is ever visible, and words outside the target slice keep their value.
- R7: `mem_req_valid` and `mem_req_addr` stay stable until accepted, and no request is raised while a read is outstanding.
- R8: A start seen while idle raises `busy` from the next cycle. Each disabled element takes one cycle, and each enabled element takes one cycle past its response. A commit cycle follows the last element, and `done` is high for exactly one cycle after it, with `busy` low in that cycle.
- R9: `start` and the request fields are ignored while `busy` is high.
- R10: After reset the block is idle, `done` and `mem_req_valid` are low, and every tile word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load using the request fields (ignored while busy) |
| req_tile | input | 3 | Destination tile number |
| req_vert | input | 1 | 0 = write a row, 1 = write a column |
| req_index | input | 32 | Slice index value |
| req_offs | input | 1 | Immediate increment added to the slice index |
| req_pred | input | 32 | Byte-granular predicate, bit 8*e enables element e |
| req_base | input | 64 | Base byte address |
| req_eoff | input | 64 | Element offset, scaled by 8 |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse after the slice is written |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| rd_tile | input | 3 | Readback tile number |
| rd_vert | input | 1 | Readback row (0) or column (1) |
| rd_slice | input | 2 | Readback slice number |
| rd_data | output | 256 | Readback vector |

## Verification
Every output of the block except the readback is a registered function of its state. A request therefore shows in the cycle after a start is accepted, after a disabled element is skipped, or after a response arrives. The tile write lands at the edge that ends the commit cycle, and `done` and the new readback value appear together in the following cycle. The bench keeps a behavioural model that steps once per clock using exactly the inputs it drove before that edge. It then compares `busy`, `done`, the request valid and address, and the readback vector in the middle of the following low phase, so each result is checked in the cycle it falls due. A final sweep reads every row and column of every tile.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int WORD_W     = 64;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LANE,
    SEQ_WAIT,
    SEQ_COMMIT
  } seq_state_e;
endpackage

// File: rtl/tsl_slice_calc.sv
module tsl_slice_calc #(
  parameter int NELEM = 4,
  parameter int SW    = 2
) (
  input  logic [31:0]   index_val,
  input  logic          index_inc,
  output logic [SW-1:0] slice
);
  // 33-bit sum: the increment must not wrap the 32-bit index before the modulo
  logic [32:0] sum;
  assign sum   = {1'b0, index_val} + {32'd0, index_inc};
  assign slice = SW'(sum % 33'(NELEM));
endmodule

// File: rtl/tsl_lane_seq.sv
module tsl_lane_seq
  import tsl_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int NELEM = 4,
  parameter int NTILE = 8,
  parameter int SW    = 2,
  parameter int TW    = 3,
  parameter int PW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TW-1:0]     in_tile,
  input  logic              in_vert,
  input  logic [SW-1:0]     in_slice,
  input  logic [PW-1:0]     in_pred,
  input  logic [63:0]       in_base,
  input  logic [63:0]       in_eoff,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              wr_en,
  output logic [TW-1:0]     wr_tile,
  output logic              wr_vert,
  output logic [SW-1:0]     wr_slice,
  output logic [VLEN-1:0]   wr_vec
);
  localparam logic [SW-1:0] LAST_ELEM = SW'(NELEM - 1);

  seq_state_e          state_q;
  logic [SW-1:0]       elem_q;
  logic [PW-1:0]       pred_q;
  logic [63:0]         base_q;
  logic [63:0]         eoff_q;
  logic [TW-1:0]       tile_q;
  logic                vert_q;
  logic [SW-1:0]       slice_q;
  logic [WORD_W-1:0]   lane_q [NELEM];
  logic                done_q;

  logic                lane_on;
  logic                lane_last;
  logic [63:0]         elem_idx;

  // element e is governed by the lowest bit of its byte group
  assign lane_on   = pred_q[elem_q * 8];
  assign lane_last = (elem_q == LAST_ELEM);
  assign elem_idx  = eoff_q + 64'(elem_q);

  assign mem_req_valid = (state_q == SEQ_LANE) && lane_on;
  assign mem_req_addr  = base_q + (elem_idx << $clog2(WORD_BYTES));

  assign busy     = (state_q != SEQ_IDLE);
  assign done     = done_q;
  assign wr_en    = (state_q == SEQ_COMMIT);
  assign wr_tile  = tile_q;
  assign wr_vert  = vert_q;
  assign wr_slice = slice_q;

  for (genvar g = 0; g < NELEM; g++) begin : g_pack
    assign wr_vec[g*WORD_W +: WORD_W] = lane_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      elem_q  <= '0;
      pred_q  <= '0;
      base_q  <= '0;
      eoff_q  <= '0;
      tile_q  <= '0;
      vert_q  <= 1'b0;
      slice_q <= '0;
      done_q  <= 1'b0;
      for (int i = 0; i < NELEM; i++) lane_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            pred_q  <= in_pred;
            base_q  <= in_base;
            eoff_q  <= in_eoff;
            tile_q  <= in_tile;
            vert_q  <= in_vert;
            slice_q <= in_slice;
            elem_q  <= '0;
            state_q <= SEQ_LANE;
          end
        end
        SEQ_LANE: begin
          if (lane_on) begin
            if (mem_req_ready) state_q <= SEQ_WAIT;
          end else begin
            lane_q[elem_q] <= '0;
            if (lane_last) begin
              state_q <= SEQ_COMMIT;
            end else begin
              elem_q <= elem_q + SW'(1);
            end
          end
        end
        SEQ_WAIT: begin
          if (mem_rsp_valid) begin
            lane_q[elem_q] <= mem_rsp_data;
            if (lane_last) begin
              state_q <= SEQ_COMMIT;
            end else begin
              elem_q  <= elem_q + SW'(1);
              state_q <= SEQ_LANE;
            end
          end
        end
        SEQ_COMMIT: begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsl_tile_array.sv
module tsl_tile_array
  import tsl_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int NELEM = 4,
  parameter int NTILE = 8,
  parameter int SW    = 2,
  parameter int TW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TW-1:0]   wr_tile,
  input  logic            wr_vert,
  input  logic [SW-1:0]   wr_slice,
  input  logic [VLEN-1:0] wr_vec,
  input  logic [TW-1:0]   rd_tile,
  input  logic            rd_vert,
  input  logic [SW-1:0]   rd_slice,
  output logic [VLEN-1:0] rd_data
);
  localparam int NWORDS = NTILE * NELEM * NELEM;

  logic [NWORDS*WORD_W-1:0] all_words;

  for (genvar t = 0; t < NTILE; t++) begin : g_tile
    for (genvar r = 0; r < NELEM; r++) begin : g_row
      for (genvar c = 0; c < NELEM; c++) begin : g_col
        logic              hit;
        logic [WORD_W-1:0] word_q;
        // a row write hits column c with element c, a column write hits row r with element r
        assign hit = wr_en && (wr_tile == TW'(t)) &&
                     (wr_vert ? (wr_slice == SW'(c)) : (wr_slice == SW'(r)));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   word_q <= '0;
          else if (hit) word_q <= wr_vert ? wr_vec[r*WORD_W +: WORD_W]
                                          : wr_vec[c*WORD_W +: WORD_W];
        end
        assign all_words[((t*NELEM + r)*NELEM + c)*WORD_W +: WORD_W] = word_q;
      end
    end
  end

  always_comb begin
    for (int e = 0; e < NELEM; e++) begin
      int widx;
      if (rd_vert) widx = (int'(rd_tile)*NELEM + e)*NELEM + int'(rd_slice);
      else         widx = (int'(rd_tile)*NELEM + int'(rd_slice))*NELEM + e;
      rd_data[e*WORD_W +: WORD_W] = all_words[widx*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/tile_slice_loader.sv
module tile_slice_loader #(
  parameter  int VLEN  = 256,
  parameter  int NTILE = 8,
  localparam int NELEM = VLEN / 64,
  localparam int SW    = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int TW    = (NTILE > 1) ? $clog2(NTILE) : 1,
  localparam int PW    = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TW-1:0]   req_tile,
  input  logic            req_vert,
  input  logic [31:0]     req_index,
  input  logic            req_offs,
  input  logic [PW-1:0]   req_pred,
  input  logic [63:0]     req_base,
  input  logic [63:0]     req_eoff,
  output logic            busy,
  output logic            done,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [63:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  input  logic [TW-1:0]   rd_tile,
  input  logic            rd_vert,
  input  logic [SW-1:0]   rd_slice,
  output logic [VLEN-1:0] rd_data
);
  logic [SW-1:0]   start_slice;
  logic            wr_en;
  logic [TW-1:0]   wr_tile;
  logic            wr_vert;
  logic [SW-1:0]   wr_slice;
  logic [VLEN-1:0] wr_vec;

  tsl_slice_calc #(.NELEM(NELEM), .SW(SW)) u_slice_calc (
    .index_val (req_index),
    .index_inc (req_offs),
    .slice     (start_slice)
  );

  tsl_lane_seq #(
    .VLEN(VLEN), .NELEM(NELEM), .NTILE(NTILE), .SW(SW), .TW(TW), .PW(PW)
  ) u_lane_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .in_tile       (req_tile),
    .in_vert       (req_vert),
    .in_slice      (start_slice),
    .in_pred       (req_pred),
    .in_base       (req_base),
    .in_eoff       (req_eoff),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .wr_en         (wr_en),
    .wr_tile       (wr_tile),
    .wr_vert       (wr_vert),
    .wr_slice      (wr_slice),
    .wr_vec        (wr_vec)
  );

  tsl_tile_array #(
    .VLEN(VLEN), .NELEM(NELEM), .NTILE(NTILE), .SW(SW), .TW(TW)
  ) u_tile_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_tile  (wr_tile),
    .wr_vert  (wr_vert),
    .wr_slice (wr_slice),
    .wr_vec   (wr_vec),
    .rd_tile  (rd_tile),
    .rd_vert  (rd_vert),
    .rd_slice (rd_slice),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker #(
  parameter  int VLEN  = 256,
  parameter  int NTILE = 8,
  localparam int NELEM = VLEN / 64,
  localparam int SW    = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int TW    = (NTILE > 1) ? $clog2(NTILE) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [63:0]     mem_req_addr,
  input logic            mem_rsp_valid,
  input logic [TW-1:0]   rd_tile,
  input logic            rd_vert,
  input logic [SW-1:0]   rd_slice,
  input logic [VLEN-1:0] rd_data
);
  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
    else if (mem_rsp_valid)                  in_flight <= 1'b0;
  end

  // R7: an unaccepted request keeps its address
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7: one read outstanding at most
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !mem_req_valid);

  // R8: done lasts one cycle and never overlaps busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: start while idle makes the block busy next cycle
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6: the readback cannot move between two busy cycles
  a_r6_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(rd_tile) && $stable(rd_vert) && $stable(rd_slice))
      |-> $stable(rd_data));
endmodule

bind tile_slice_loader tsl_checker #(.VLEN(VLEN), .NTILE(NTILE)) u_tsl_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .rd_tile       (rd_tile),
  .rd_vert       (rd_vert),
  .rd_slice      (rd_slice),
  .rd_data       (rd_data)
);

// File: tb/test_tile_slice_loader.sv
module test_tile_slice_loader;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 256;
  localparam int NE   = 4;
  localparam int NT   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            start;
  logic [2:0]      req_tile;
  logic            req_vert;
  logic [31:0]     req_index;
  logic            req_offs;
  logic [31:0]     req_pred;
  logic [63:0]     req_base;
  logic [63:0]     req_eoff;
  logic            busy, done;
  logic            mem_req_valid, mem_req_ready;
  logic [63:0]     mem_req_addr;
  logic            mem_rsp_valid;
  logic [63:0]     mem_rsp_data;
  logic [2:0]      rd_tile;
  logic            rd_vert;
  logic [1:0]      rd_slice;
  logic [VLEN-1:0] rd_data;

  tile_slice_loader i_tile_slice_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_tile(req_tile), .req_vert(req_vert), .req_index(req_index), .req_offs(req_offs),
    .req_pred(req_pred), .req_base(req_base), .req_eoff(req_eoff),
    .busy(busy), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rd_tile(rd_tile), .rd_vert(rd_vert), .rd_slice(rd_slice), .rd_data(rd_data)
  );

  typedef struct {
    logic [2:0]  tile;
    logic        vert;
    logic [31:0] idx;
    logic        offs;
    logic [31:0] pred;
    logic [63:0] base;
    logic [63:0] eoff;
  } req_t;

  req_t rq[$];
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0, sweep = 0;
  int   sweep_k = 0, gap = 0;

  // reference model state
  int          ph = 0;   // 0 idle, 1 element, 2 awaiting data, 3 commit
  int          el = 0;
  logic [2:0]  m_tile;
  logic        m_vert;
  int          m_slice;
  logic [31:0] m_pred;
  logic [63:0] m_base, m_eoff;
  logic [63:0] m_buf [NE];
  bit          exp_done = 0;
  logic [63:0] ref_tile [NT][NE][NE];

  // memory model
  bit          pend = 0;
  int          pdly = 0;
  logic [63:0] paddr;

  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    return {a[31:0], ~a[63:32]} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] ref_read(input logic [2:0] t, input logic v, input logic [1:0] s);
    logic [VLEN-1:0] r;
    for (int e = 0; e < NE; e++)
      r[e*64 +: 64] = v ? ref_tile[t][e][s] : ref_tile[t][s][e];
    return r;
  endfunction

  always @(negedge clk) begin : drive_and_model
    bit ev;
    logic [63:0] eaddr;
    if (rst_n && !finished) begin
      // compare outputs due in this cycle
      ev    = (ph == 1) && m_pred[el*8];
      eaddr = m_base + ((m_eoff + 64'(el)) << 3);
      chk(busy === (ph != 0), "R8", "busy", busy, (ph != 0));
      chk(done === exp_done, "R8", "done", done, exp_done);
      chk(mem_req_valid === ev, "R3/R7/R9", "mem_req_valid", mem_req_valid, ev);
      if (ev) chk(mem_req_addr === eaddr, "R2", "mem_req_addr", mem_req_addr, eaddr);
      chk(rd_data === ref_read(rd_tile, rd_vert, rd_slice), "R1/R4/R5/R6", "rd_data",
          rd_data, ref_read(rd_tile, rd_vert, rd_slice));

      // drive inputs for the coming edge
      start = 1'b0;
      if (ph == 0 && rq.size() > 0 && gap == 0) begin
        req_t r;
        r = rq.pop_front();
        start = 1'b1;
        req_tile = r.tile; req_vert = r.vert; req_index = r.idx; req_offs = r.offs;
        req_pred = r.pred; req_base = r.base; req_eoff = r.eoff;
        gap = $urandom % 3;
      end else begin
        if (ph == 0 && gap > 0) gap--;
        req_tile = 3'($urandom); req_vert = 1'($urandom); req_index = $urandom;
        req_offs = 1'($urandom); req_pred = $urandom;
        req_base = {$urandom, $urandom}; req_eoff = {$urandom, $urandom};
        // R9: stray start while busy must change nothing
        if (ph != 0 && ($urandom % 4 == 0)) start = 1'b1;
      end
      mem_req_ready = ($urandom % 3) != 0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = {$urandom, $urandom};
      if (pend) begin
        if (pdly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_fn(paddr);
          pend = 0;
        end else pdly--;
      end
      if (ev && mem_req_ready) begin
        pend = 1; pdly = $urandom % 3; paddr = eaddr;
      end
      if (sweep) begin
        rd_tile = 3'(sweep_k >> 3); rd_vert = sweep_k[2]; rd_slice = 2'(sweep_k);
        sweep_k = (sweep_k + 1) % 64;
      end else begin
        rd_tile = 3'($urandom); rd_vert = 1'($urandom); rd_slice = 2'($urandom);
      end

      // advance the model across the coming edge
      exp_done = (ph == 3);
      case (ph)
        0: if (start) begin
          m_tile = req_tile; m_vert = req_vert; m_pred = req_pred;
          m_base = req_base; m_eoff = req_eoff;
          m_slice = int'((longint'(req_index) + longint'(req_offs)) % NE);
          el = 0; ph = 1;
        end
        1: if (m_pred[el*8]) begin
          if (mem_req_ready) ph = 2;
        end else begin
          m_buf[el] = '0;
          if (el == NE-1) ph = 3; else el++;
        end
        2: if (mem_rsp_valid) begin
          m_buf[el] = mem_rsp_data;
          if (el == NE-1) ph = 3; else begin el++; ph = 1; end
        end
        default: begin
          for (int e = 0; e < NE; e++) begin
            if (m_vert) ref_tile[m_tile][e][m_slice] = m_buf[e];
            else        ref_tile[m_tile][m_slice][e] = m_buf[e];
          end
          ph = 0;
        end
      endcase
    end
  end

  task automatic add_req(input logic [2:0] t, input logic v, input logic [31:0] i, input logic o,
                         input logic [31:0] p, input logic [63:0] b, input logic [63:0] f);
    req_t r;
    r.tile = t; r.vert = v; r.idx = i; r.offs = o; r.pred = p; r.base = b; r.eoff = f;
    rq.push_back(r);
  endtask

  initial begin
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NE; r++)
        for (int c = 0; c < NE; c++) ref_tile[t][r][c] = '0;
    start = 0; req_tile = 0; req_vert = 0; req_index = 0; req_offs = 0; req_pred = 0;
    req_base = 0; req_eoff = 0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    rd_tile = 3'd5; rd_vert = 1'b1; rd_slice = 2'd2;

    add_req(3'd0, 1'b0, 32'd0, 1'b0, 32'h0101_0101, 64'h1000, 64'd0);         // all enabled, row 0
    add_req(3'd3, 1'b1, 32'd5, 1'b1, 32'h0001_0001, 64'h8000, 64'd4);         // R1: 6 mod 4 = 2, R3 lanes 0,2
    add_req(3'd0, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'h0, 64'h0, 64'd0);            // R1 wrap to 0, R3 all zero
    add_req(3'd3, 1'b1, 32'd2, 1'b0, 32'hFEFE_FEFE, 64'h40, 64'd1);           // R3 upper bits ignored
    add_req(3'd5, 1'b0, 32'd3, 1'b0, 32'h0101_0101, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1); // R2 wrap
    add_req(3'd5, 1'b1, 32'd2, 1'b1, 32'h0100_0000, 64'h200, 64'd7);          // R5 column 3, lane 3 only
    for (int k = 0; k < 24; k++)
      add_req(3'($urandom), 1'($urandom), $urandom, 1'($urandom), $urandom,
              {$urandom, $urandom}, {$urandom, $urandom});

    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy === 1'b0, "R10", "busy in reset", busy, 0);
    chk(done === 1'b0, "R10", "done in reset", done, 0);
    chk(mem_req_valid === 1'b0, "R10", "mem_req_valid in reset", mem_req_valid, 0);
    chk(rd_data === '0, "R10", "rd_data in reset", rd_data, 0);
    #1 rst_n = 1'b1;

    wait (rq.size() == 0 && ph == 0);
    repeat (6) @(posedge clk);
    sweep = 1;
    repeat (70) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule